// File: doc/BRIEF.md
# Deferred Masked Write-Back Buffer

This block holds register updates produced while an instruction bundle executes and applies them all at once when the bundle ends. A client posts update entries during the bundle; each entry names a destination, a keep-mask and a data word. A commit folds every pending entry into a sixteen-entry, 16-bit register file and a pair of 40-bit accumulators. The fold uses the rule new = (old AND keep) OR data and takes the entries in the order they were posted. A discard throws every pending entry away and leaves the file untouched.

The read ports only ever show committed state. Pending entries are never forwarded, so both halves of a parallel pair read the values that were in place before the bundle began. The post interface is a valid/ready channel. `post_ready_o` is held high permanently, so a post is consumed in every cycle in which `post_valid_i` is high. A post that does not fit in the remaining capacity is consumed and then dropped, and the overflow flag is raised. No back-pressure is ever applied.

Top module: `defer_wb`

## Requirements
- R1: After reset every general register and both accumulators read zero, the queue is empty, `ovf_o` is 0 and `post_ready_o` is 1.
- R2: The read ports and `acc_o` show committed values only. A posted but uncommitted entry never changes what they return.
- R3: At commit each entry sets its destination to (old AND keep) OR data, with no masking of the data word by the keep-mask. For general registers only bits 15:0 of the keep and data fields are used.
- R4: Post kind 2'b00 (plain) forces the keep-mask to zero, so the destination is fully replaced by the data. Kinds 2'b01 and 2'b11 (masked) use `post_keep_i`.
- R5: Entries are applied in posting order, so for the same destination the last-posted entry is applied last.
- R6: Post kind 2'b10 (pair) writes `post_data_i[31:16]` to register N and `post_data_i[15:0]` to register (N+1) mod 16, both with a zero keep-mask. N is `post_dst_i[3:0]`, and the pair takes two queue slots.
- R7: Destination codes 16 and 17 select accumulators 0 and 1. Their data and keep are truncated to 40 bits (`post_data_i[39:0]`). `acc_o[39:0]` is accumulator 0 and `acc_o[79:40]` is accumulator 1.
- R8: `discard_i` empties the queue without changing any register. When `commit_i` and `discard_i` are high in the same cycle, the discard wins.
- R9: The queue holds 16 entries. A post that needs more slots than remain free is dropped whole, including a pair with only one free slot, and `ovf_o` becomes 1 from the next cycle. `ovf_o` stays at 1 until a commit or discard clears it in the following cycle.
- R10: A post in the same cycle as a commit or discard enters the fresh queue after the flush and is applied only by a later commit.
- R11: Destination codes 18 to 31 take a slot but write nothing at commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| post_valid_i | input | 1 | Post request valid |
| post_ready_o | output | 1 | Always 1; every valid post is consumed |
| post_kind_i | input | 2 | 00 plain, 01/11 masked, 10 register pair |
| post_dst_i | input | 5 | Destination: 0-15 register, 16/17 accumulator |
| post_keep_i | input | 40 | Keep-mask, 1 bits preserve the old value |
| post_data_i | input | 64 | Data word |
| commit_i | input | 1 | Apply all pending entries this cycle |
| discard_i | input | 1 | Drop all pending entries this cycle |
| ovf_o | output | 1 | Sticky overflow flag |
| rd_idx_i | input | 8 | Two 4-bit register read indices |
| rd_data_o | output | 32 | Two 16-bit committed read values |
| acc_o | output | 80 | Both accumulators, committed values |

## Verification
Two pairs of functions can land in the same cycle: a post together with a commit or discard, and a commit together with a discard. The bench provokes the first by holding a post and a commit (or a discard) high across the same edge. It then checks that the register still holds the earlier value and changes only on the next commit. It provokes the second by raising both flush inputs together and checking that the pending value never reaches the file. Ordering is judged by masked updates whose result differs when applied in the opposite order.

// File: rtl/dwb_pkg.sv
package dwb_pkg;
  localparam int GPR_N  = 16;
  localparam int GPR_W  = 16;
  localparam int ACC_N  = 2;
  localparam int ACC_W  = 40;
  localparam int IDX_W  = 5;
  localparam int ENT_W  = ACC_W;
  localparam int GIDX_W = $clog2(GPR_N);
  localparam int TGT_N  = GPR_N + ACC_N;

  typedef enum logic [1:0] {
    K_PLAIN = 2'b00,
    K_MASK  = 2'b01,
    K_PAIR  = 2'b10,
    K_MASK2 = 2'b11
  } kind_e;

  typedef struct packed {
    logic [IDX_W-1:0] dst;
    logic [ENT_W-1:0] keep;
    logic [ENT_W-1:0] data;
  } ent_t;
endpackage

// File: rtl/dwb_post_fmt.sv
module dwb_post_fmt
  import dwb_pkg::*;
#(
  parameter int DIN_W = 64
) (
  input  logic [1:0]       kind_i,
  input  logic [IDX_W-1:0] dst_i,
  input  logic [ENT_W-1:0] keep_i,
  input  logic [DIN_W-1:0] data_i,
  output ent_t             e0_o,
  output ent_t             e1_o,
  output logic             two_o
);
  logic [GIDX_W-1:0] lo_idx;
  logic              unused_hi;

  assign lo_idx    = dst_i[GIDX_W-1:0] + 1'b1;
  assign unused_hi = ^data_i[DIN_W-1:ENT_W];

  always_comb begin
    e0_o  = '0;
    e1_o  = '0;
    two_o = 1'b0;
    case (kind_i)
      K_PLAIN: begin
        e0_o.dst  = dst_i;
        e0_o.keep = '0;
        e0_o.data = data_i[ENT_W-1:0];
      end
      K_PAIR: begin
        two_o     = 1'b1;
        e0_o.dst  = IDX_W'(dst_i[GIDX_W-1:0]);
        e0_o.data = ENT_W'(data_i[2*GPR_W-1:GPR_W]);
        e1_o.dst  = IDX_W'(lo_idx);
        e1_o.data = ENT_W'(data_i[GPR_W-1:0]);
      end
      default: begin
        e0_o.dst  = dst_i;
        e0_o.keep = keep_i;
        e0_o.data = data_i[ENT_W-1:0];
      end
    endcase
  end
endmodule

// File: rtl/dwb_queue.sv
module dwb_queue
  import dwb_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             post_valid_i,
  input  ent_t             e0_i,
  input  ent_t             e1_i,
  input  logic             two_i,
  input  logic             flush_i,
  output ent_t             ent_o [DEPTH],
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  ent_t             ent_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic [CNT_W-1:0] base, need, room;
  logic             fits, take;

  always_comb begin
    base = flush_i ? '0 : cnt_q;
    need = two_i ? CNT_W'(2) : CNT_W'(1);
    room = CNT_W'(DEPTH) - base;
    fits = (need <= room);
    take = post_valid_i && fits;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= base + (take ? need : CNT_W'(0));
      if (flush_i)
        ovf_q <= 1'b0;
      else if (post_valid_i && !fits)
        ovf_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (take && CNT_W'(i) == base)
        ent_q[i] <= e0_i;
      if (take && two_i && CNT_W'(i) == base + CNT_W'(1))
        ent_q[i] <= e1_i;
    end
  end

  assign ent_o = ent_q;
  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  // R9: occupancy never exceeds capacity
  a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH));
  // R9: a post that does not fit raises the flag
  a_r9_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
    (post_valid_i && !flush_i && (need > CNT_W'(DEPTH) - cnt_q)) |=> ovf_q);
  // R9: any flush clears the flag
  a_r9_ovf_clear: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !ovf_q);
  // R8 R10: a flush with no post leaves the queue empty
  a_r10_flush_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_i && !post_valid_i) |=> (cnt_q == '0));
endmodule

// File: rtl/dwb_file.sv
module dwb_file
  import dwb_pkg::*;
#(
  parameter  int DEPTH = 16,
  parameter  int NRD   = 2,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    commit_i,
  input  logic                    discard_i,
  input  ent_t                    ent_i [DEPTH],
  input  logic [CNT_W-1:0]        cnt_i,
  input  logic [NRD*GIDX_W-1:0]   rd_idx_i,
  output logic [NRD*GPR_W-1:0]    rd_data_o,
  output logic [ACC_N*ACC_W-1:0]  acc_o
);
  logic [GPR_N-1:0][GPR_W-1:0] gpr_q;
  logic [ACC_N-1:0][ACC_W-1:0] acc_q;
  logic [TGT_N-1:0][ENT_W-1:0] cur, nxt;
  logic                        do_commit;

  assign do_commit = commit_i && !discard_i;

  for (genvar t = 0; t < TGT_N; t++) begin : g_cur
    if (t < GPR_N) begin : g_reg
      assign cur[t] = {{(ENT_W-GPR_W){1'b0}}, gpr_q[t]};
      logic unused_up;
      assign unused_up = ^nxt[t][ENT_W-1:GPR_W];
    end else begin : g_acc
      assign cur[t] = acc_q[t-GPR_N];
    end
  end

  always_comb begin
    logic [ENT_W-1:0] v;
    for (int t = 0; t < TGT_N; t++) begin
      v = cur[t];
      for (int i = 0; i < DEPTH; i++) begin
        if (CNT_W'(i) < cnt_i && ent_i[i].dst == IDX_W'(t))
          v = (v & ent_i[i].keep) | ent_i[i].data;
      end
      nxt[t] = v;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gpr_q <= '0;
      acc_q <= '0;
    end else if (do_commit) begin
      for (int t = 0; t < GPR_N; t++)
        gpr_q[t] <= nxt[t][GPR_W-1:0];
      for (int a = 0; a < ACC_N; a++)
        acc_q[a] <= nxt[GPR_N+a];
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rd_data_o[p*GPR_W +: GPR_W] = gpr_q[rd_idx_i[p*GIDX_W +: GIDX_W]];
  end

  for (genvar a = 0; a < ACC_N; a++) begin : g_accout
    assign acc_o[a*ACC_W +: ACC_W] = acc_q[a];
  end

  // R2: without a commit the committed state does not move
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> ($stable(gpr_q) && $stable(acc_q)));
  // R8: a discard never writes the file, even with commit
  a_r8_discard_wins: assert property (@(posedge clk) disable iff (!rst_n)
    discard_i |=> ($stable(gpr_q) && $stable(acc_q)));
  // R11: a commit with an empty queue changes nothing
  a_r11_empty_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_i && cnt_i == '0) |=> ($stable(gpr_q) && $stable(acc_q)));
endmodule

// File: rtl/defer_wb.sv
module defer_wb
  import dwb_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int NRD   = 2,
  parameter int DIN_W = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   post_valid_i,
  output logic                   post_ready_o,
  input  logic [1:0]             post_kind_i,
  input  logic [IDX_W-1:0]       post_dst_i,
  input  logic [ENT_W-1:0]       post_keep_i,
  input  logic [DIN_W-1:0]       post_data_i,
  input  logic                   commit_i,
  input  logic                   discard_i,
  output logic                   ovf_o,
  input  logic [NRD*GIDX_W-1:0]  rd_idx_i,
  output logic [NRD*GPR_W-1:0]   rd_data_o,
  output logic [ACC_N*ACC_W-1:0] acc_o
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  ent_t             e0, e1;
  logic             two;
  ent_t             ents [DEPTH];
  logic [CNT_W-1:0] cnt;

  assign post_ready_o = 1'b1;

  dwb_post_fmt #(.DIN_W(DIN_W)) u_fmt (
    .kind_i (post_kind_i),
    .dst_i  (post_dst_i),
    .keep_i (post_keep_i),
    .data_i (post_data_i),
    .e0_o   (e0),
    .e1_o   (e1),
    .two_o  (two)
  );

  dwb_queue #(.DEPTH(DEPTH)) u_q (
    .clk          (clk),
    .rst_n        (rst_n),
    .post_valid_i (post_valid_i),
    .e0_i         (e0),
    .e1_i         (e1),
    .two_i        (two),
    .flush_i      (commit_i || discard_i),
    .ent_o        (ents),
    .cnt_o        (cnt),
    .ovf_o        (ovf_o)
  );

  dwb_file #(.DEPTH(DEPTH), .NRD(NRD)) u_rf (
    .clk       (clk),
    .rst_n     (rst_n),
    .commit_i  (commit_i),
    .discard_i (discard_i),
    .ent_i     (ents),
    .cnt_i     (cnt),
    .rd_idx_i  (rd_idx_i),
    .rd_data_o (rd_data_o),
    .acc_o     (acc_o)
  );
endmodule

// File: tb/sim_defer_wb.sv
`timescale 1ns/1ps
module sim_defer_wb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        post_valid_i = 1'b0;
  logic        post_ready_o;
  logic [1:0]  post_kind_i = '0;
  logic [4:0]  post_dst_i = '0;
  logic [39:0] post_keep_i = '0;
  logic [63:0] post_data_i = '0;
  logic        commit_i = 1'b0;
  logic        discard_i = 1'b0;
  logic        ovf_o;
  logic [7:0]  rd_idx_i = '0;
  logic [31:0] rd_data_o;
  logic [79:0] acc_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  defer_wb u0 (.*);

  typedef struct packed {
    logic [1:0]  kind;
    logic [4:0]  dst;
    logic [39:0] keep;
    logic [63:0] data;
    logic        cm;
    logic [3:0]  ci;
    logic [15:0] ex;
  } vec_t;

  // R3 R4 R5 R6 and R2 (entry 2 is posted but not committed)
  localparam vec_t TBL [10] = '{
    '{2'd0, 5'd3,  40'h0,    64'h1234,              1'b1, 4'd3,  16'h1234},
    '{2'd1, 5'd3,  40'hFF00, 64'h0056,              1'b1, 4'd3,  16'h1256},
    '{2'd0, 5'd5,  40'h0,    64'hAAAA,              1'b0, 4'd5,  16'h0000},
    '{2'd1, 5'd5,  40'h0F0F, 64'h5050,              1'b1, 4'd5,  16'h5A5A},
    '{2'd0, 5'd7,  40'h0,    64'hFFFF,              1'b1, 4'd7,  16'hFFFF},
    '{2'd0, 5'd7,  40'hFFFF, 64'h0001,              1'b1, 4'd7,  16'h0001},
    '{2'd1, 5'd9,  40'hFFFF, 64'h00F0,              1'b1, 4'd9,  16'h00F0},
    '{2'd1, 5'd9,  40'h00FF, 64'h0F0F,              1'b1, 4'd9,  16'h0FFF},
    '{2'd2, 5'd12, 40'h0,    64'h11112222,          1'b1, 4'd12, 16'h1111},
    '{2'd0, 5'd4,  40'h0,    64'hFFFFFFFF00004321,  1'b1, 4'd4,  16'h4321}
  };

  task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic p, input logic [1:0] k, input logic [4:0] d,
                      input logic [39:0] m, input logic [63:0] v,
                      input logic c, input logic x);
    @(negedge clk);
    post_valid_i = p; post_kind_i = k; post_dst_i = d;
    post_keep_i = m;  post_data_i = v;
    commit_i = c;     discard_i = x;
    @(negedge clk);
    post_valid_i = 1'b0; commit_i = 1'b0; discard_i = 1'b0;
  endtask

  task automatic post(input logic [1:0] k, input logic [4:0] d,
                      input logic [39:0] m, input logic [63:0] v);
    step(1'b1, k, d, m, v, 1'b0, 1'b0);
  endtask

  task automatic commit();
    step(1'b0, 2'd0, 5'd0, 40'h0, 64'h0, 1'b1, 1'b0);
  endtask

  task automatic rd(input logic [3:0] i, output logic [15:0] v);
    rd_idx_i[3:0] = i;
    #0.5;
    v = rd_data_o[15:0];
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_idx_i = 8'h10;
    #0.5;
    chk("R1 rd0", 80'(rd_data_o[15:0]), 80'h0);
    chk("R1 rd1", 80'(rd_data_o[31:16]), 80'h0);
    chk("R1 acc", acc_o, 80'h0);
    chk("R1 ovf", 80'(ovf_o), 80'h0);
    chk("R1 ready", 80'(post_ready_o), 80'h1);

    foreach (TBL[i]) begin
      post(TBL[i].kind, TBL[i].dst, TBL[i].keep, TBL[i].data);
      if (TBL[i].cm) commit();
      rd(TBL[i].ci, r);
      chk($sformatf("table %0d (R3 R4 R5 R6)", i), 80'(r), 80'(TBL[i].ex));
    end
    rd(4'd13, r);
    chk("R6 pair low half", 80'(r), 80'h2222);

    // R2: pending write invisible on the second read port too
    post(2'd0, 5'd1, 40'h0, 64'h7777);
    rd_idx_i[7:4] = 4'd1;
    #0.5;
    chk("R2 pending hidden", 80'(rd_data_o[31:16]), 80'h0);
    commit();
    #0.5;
    chk("R2 visible after commit", 80'(rd_data_o[31:16]), 80'h7777);

    // R6: pair wraps from 15 to 0
    post(2'd2, 5'd15, 40'hFF_FFFF_FFFF, 64'hABCD0123);
    commit();
    rd(4'd15, r); chk("R6 upper to 15", 80'(r), 80'hABCD);
    rd(4'd0, r);  chk("R6 lower wraps to 0", 80'(r), 80'h0123);

    // R7 accumulators
    post(2'd0, 5'd16, 40'h0, 64'h1234_5678_9ABC_DEF0);
    post(2'd0, 5'd17, 40'h0, 64'hFFFF_FFFF_FFFF_FFFF);
    commit();
    #0.5;
    chk("R7 acc0 truncated", 80'(acc_o[39:0]), 80'h78_9ABC_DEF0);
    chk("R7 acc1 truncated", 80'(acc_o[79:40]), 80'hFF_FFFF_FFFF);
    post(2'd1, 5'd17, 40'h00_0000_00FF, 64'h11_0000_0000);
    commit();
    #0.5;
    chk("R7 acc1 masked", 80'(acc_o[79:40]), 80'h11_0000_00FF);

    // R8 discard, then discard together with commit
    post(2'd0, 5'd2, 40'h0, 64'h5555);
    step(1'b0, 2'd0, 5'd0, 40'h0, 64'h0, 1'b0, 1'b1);
    commit();
    rd(4'd2, r); chk("R8 discard drops", 80'(r), 80'h0);
    post(2'd0, 5'd2, 40'h0, 64'h6666);
    step(1'b0, 2'd0, 5'd0, 40'h0, 64'h0, 1'b1, 1'b1);
    rd(4'd2, r); chk("R8 discard beats commit", 80'(r), 80'h0);
    commit();
    rd(4'd2, r); chk("R8 queue emptied", 80'(r), 80'h0);

    // R9 capacity and overflow
    for (int i = 1; i <= 16; i++) post(2'd0, 5'd6, 40'h0, 64'(i));
    chk("R9 full no ovf", 80'(ovf_o), 80'h0);
    post(2'd0, 5'd6, 40'h0, 64'h99);
    chk("R9 ovf raised", 80'(ovf_o), 80'h1);
    commit();
    rd(4'd6, r); chk("R9 extra dropped", 80'(r), 80'h10);
    chk("R9 ovf cleared", 80'(ovf_o), 80'h0);
    for (int i = 1; i <= 15; i++) post(2'd0, 5'd8, 40'h0, 64'(i));
    post(2'd2, 5'd14, 40'h0, 64'hAAAABBBB);
    chk("R9 pair ovf", 80'(ovf_o), 80'h1);
    commit();
    rd(4'd8, r);  chk("R9 kept entries", 80'(r), 80'hF);
    rd(4'd14, r); chk("R9 pair dropped hi", 80'(r), 80'h0);
    rd(4'd15, r); chk("R9 pair dropped lo", 80'(r), 80'hABCD);

    // R10 post in the flush cycle belongs to the next bundle
    post(2'd0, 5'd3, 40'h0, 64'h0AAA);
    step(1'b1, 2'd0, 5'd3, 40'h0, 64'h0BEE, 1'b1, 1'b0);
    rd(4'd3, r); chk("R10 old bundle", 80'(r), 80'h0AAA);
    commit();
    rd(4'd3, r); chk("R10 next bundle", 80'(r), 80'h0BEE);
    step(1'b1, 2'd0, 5'd3, 40'h0, 64'h0CCC, 1'b0, 1'b1);
    rd(4'd3, r); chk("R10 survives discard", 80'(r), 80'h0BEE);
    commit();
    rd(4'd3, r); chk("R10 applied later", 80'(r), 80'h0CCC);

    // R11 unused destination codes
    do_reset();
    post(2'd0, 5'd20, 40'h0, 64'hFFFF_FFFF_FFFF_FFFF);
    post(2'd0, 5'd31, 40'h0, 64'hFFFF);
    commit();
    for (int i = 0; i < 16; i++) begin
      rd(4'(i), r);
      chk($sformatf("R11 reg %0d", i), 80'(r), 80'h0);
    end
    chk("R11 acc", acc_o, 80'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule